// File: doc/BRIEF.md
# Packet VM Integer ALU

This block is the combinational integer execution stage of a 64-bit register virtual machine. In one evaluation it takes an 8-bit opcode, the 16-bit offset field, the 32-bit immediate field, and the current destination and source register values. It returns the value to write back to the destination register, together with a flag that marks encodings it does not accept.

The block handles add, subtract, multiply, the three bitwise operations, left and right shifts (logical and arithmetic), negate, plain and sign-extending move, and byte reversal. Each of these exists in a 32-bit operand class and a 64-bit operand class. Division, modulo, branches, memory access and the register file belong to other stages. When the flag is raised, the output equals the destination value, so a pipeline that ignores the flag still writes back an unchanged register.

A parameter records whether the host stores data little-endian. The 32-bit class uses it to decide whether a byte-order conversion really reverses bytes or only narrows the value.

Top module: `vm_int_alu`

## Requirements
- R1: Opcode bits [2:0] give the operand class: value 4 is the 32-bit class and value 7 is the 64-bit class. Any other class value is flagged illegal.
- R2: Opcode bit 3 selects the second operand. When it is 0 the immediate is used, sign-extended from 32 to 64 bits in the 64-bit class. When it is 1 the source register is used.
- R3: The operation code in opcode bits [7:4] is 0 for add, 1 for subtract, 2 for multiply, 4 for or, 5 for and, and 0xA for xor. These wrap at the class width. In the 32-bit class the result bits [63:32] are zero.
- R4: Code 6 shifts left, code 7 shifts right logically and code 0xC shifts right arithmetically, copying the sign bit. The shift amount is the operand masked with 0x3F in the 64-bit class and with 0x1F in the 32-bit class. The 32-bit class shifts only the low 32 bits of the destination.
- R5: Code 8 gives the two's-complement negation of the destination at the class width. The selected operand has no effect on it.
- R6: Code 0xB with offset 0 copies the operand. Offset 8 or 16 sign-extends the operand's low 8 or 16 bits. Offset 32 sign-extends its low 32 bits, but only in the 64-bit class. In the 32-bit class the result is zero above bit 31.
- R7: Code 0xD reverses or narrows only the destination. The immediate gives the width, which is 16, 32 or 64, and the result is zero above that width. In the 64-bit class the bytes are always reversed.
- R8: In the 32-bit class, code 0xD with opcode bit 3 at 0 converts to little-endian and with bit 3 at 1 converts to big-endian. The bytes are reversed only when the target order differs from the host order set by parameter HOST_LITTLE (default little-endian). Otherwise the value is only narrowed to the width.
- R9: The illegal flag is raised in any of these cases: an operation code 3, 9, 0xE or 0xF; a nonzero offset on any operation other than move; a move offset outside the allowed set; a byte-reversal width other than 16, 32 or 64; or a 64-bit class byte reversal with opcode bit 3 set. While the flag is raised the result equals the destination value. For every other encoding in classes 4 and 7 the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Operation code, operand select and class |
| op_offset | input | 16 | Offset field (move sign-extension width) |
| op_imm | input | 32 | Immediate field (operand or byte-reversal width) |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| result | output | 64 | Value to write to the destination |
| illegal | output | 1 | Encoding not accepted; result equals dst_val |

## Verification
The bench tries every one of the 256 opcodes, each crossed with five offsets, five immediates and three pairs of register values.

The immediates are the three legal byte widths, a negative value and 0x21. The 0x21 value gives a shift of 33 in the 64-bit class but 1 in the 32-bit class, which tells the two shift masks apart. The negative immediate shows whether sign extension is applied in the 64-bit class and left out in the 32-bit class.

The register pairs have their top bit, bit 31, bit 15 and bit 7 set in different combinations. This separates arithmetic from logical right shift, and shows each sign-extension width of the move.

The offsets 8, 16 and 32 and an odd value show which encodings each class accepts and that illegal encodings return the destination unchanged. Directed checks also compare the same operation in the two classes and the two operand selections.

// File: rtl/vm_int_alu.sv
module vm_int_alu #(
  parameter bit HOST_LITTLE = 1'b1
) (
  input  logic [7:0]  op_code,
  input  logic [15:0] op_offset,
  input  logic [31:0] op_imm,
  input  logic [63:0] dst_val,
  input  logic [63:0] src_val,
  output logic [63:0] result,
  output logic        illegal
);
  localparam int XW = 64;
  localparam int HW = XW / 2;

  logic          wide, narrow, use_reg;
  logic [3:0]    fn;
  logic [XW-1:0] opnd, r, rev16, rev32, rev64;
  logic [XW-1:0] sra_w;
  logic [HW-1:0] sra_n;
  logic          bad, flip;

  assign wide    = op_code[2:0] == 3'd7;
  assign narrow  = op_code[2:0] == 3'd4;
  assign use_reg = op_code[3];
  assign fn      = op_code[7:4];
  assign opnd    = use_reg ? src_val : {{HW{op_imm[31]}}, op_imm};
  assign sra_w   = $signed(dst_val) >>> opnd[5:0];
  assign sra_n   = $signed(dst_val[HW-1:0]) >>> opnd[4:0];
  assign flip    = wide | (use_reg ? HOST_LITTLE : !HOST_LITTLE);

  always_comb begin
    rev16 = '0;
    rev32 = '0;
    rev64 = '0;
    for (int k = 0; k < 2; k++) rev16[8*k +: 8] = dst_val[8*(1-k) +: 8];
    for (int k = 0; k < 4; k++) rev32[8*k +: 8] = dst_val[8*(3-k) +: 8];
    for (int k = 0; k < 8; k++) rev64[8*k +: 8] = dst_val[8*(7-k) +: 8];
  end

  always_comb begin
    r   = dst_val;
    bad = !(wide || narrow);
    if (fn != 4'hB && op_offset != 16'd0) bad = 1'b1;
    case (fn)
      4'h0: r = dst_val + opnd;
      4'h1: r = dst_val - opnd;
      4'h2: r = dst_val * opnd;
      4'h4: r = dst_val | opnd;
      4'h5: r = dst_val & opnd;
      4'hA: r = dst_val ^ opnd;
      4'h6: r = wide ? dst_val << opnd[5:0] : {{HW{1'b0}}, dst_val[HW-1:0] << opnd[4:0]};
      4'h7: r = wide ? dst_val >> opnd[5:0] : {{HW{1'b0}}, dst_val[HW-1:0] >> opnd[4:0]};
      4'hC: r = wide ? sra_w : {{HW{1'b0}}, sra_n};
      4'h8: r = '0 - dst_val;
      4'hB: begin
        case (op_offset)
          16'd0:  r = opnd;
          16'd8:  r = {{(XW-8){opnd[7]}}, opnd[7:0]};
          16'd16: r = {{(XW-16){opnd[15]}}, opnd[15:0]};
          16'd32: begin
            r = {{HW{opnd[31]}}, opnd[31:0]};
            if (!wide) bad = 1'b1;
          end
          default: bad = 1'b1;
        endcase
      end
      4'hD: begin
        if (wide && use_reg) bad = 1'b1;
        case (op_imm)
          32'd16: r = flip ? rev16 : {48'b0, dst_val[15:0]};
          32'd32: r = flip ? rev32 : {32'b0, dst_val[31:0]};
          32'd64: r = flip ? rev64 : dst_val;
          default: bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
    if (narrow && fn != 4'hD) r[XW-1:HW] = '0;
  end

  assign illegal = bad;
  assign result  = bad ? dst_val : r;
endmodule

// File: rtl/vm_int_alu_props.sv
module vm_int_alu_props (
  input logic [7:0]  op_code,
  input logic [15:0] op_offset,
  input logic [31:0] op_imm,
  input logic [63:0] dst_val,
  input logic [63:0] src_val,
  input logic [63:0] result,
  input logic        illegal
);
  logic is64, is32;
  assign is64 = op_code[2:0] == 3'd7;
  assign is32 = op_code[2:0] == 3'd4;

  always_comb begin
    if (!(is64 || is32)) begin
      assert_bad_class_R1: assert (illegal);
    end
    if (illegal) begin
      assert_hold_dst_R9: assert (result == dst_val);
    end
    if (!illegal && is32 && op_code[7:4] != 4'hD) begin
      assert_upper_clear_R3: assert (result[63:32] == 32'd0);
    end
    if (!illegal && is64 && op_code[7:4] == 4'h8) begin
      assert_neg_sum_R5: assert (result + dst_val == 64'd0);
    end
    if (!illegal && is64 && op_code[7:3] == 5'b10111 && op_offset == 16'd0) begin
      assert_mov_copy_R6: assert (result == src_val);
    end
    if (!illegal && op_code[7:4] == 4'hD && op_imm == 32'd16) begin
      assert_swap_width_R7: assert (result[63:16] == 48'd0);
    end
  end
endmodule

bind vm_int_alu vm_int_alu_props u_props (.*);

// File: tb/vm_int_alu_test.sv
module vm_int_alu_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [7:0]  op_code = '0;
  logic [15:0] op_offset = '0;
  logic [31:0] op_imm = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [63:0] result;
  logic        illegal;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  vm_int_alu uut (.*);

  function automatic logic [64:0] model(input logic [7:0] op, input logic [15:0] off,
                                        input logic [31:0] imm, input logic [63:0] d,
                                        input logic [63:0] s);
    logic w64, ill, flip;
    logic [63:0] lowm, a, b, v;
    int sh, n;
    w64  = op[2:0] == 3'd7;
    ill  = !(w64 || op[2:0] == 3'd4);
    lowm = w64 ? ~64'd0 : 64'h0000_0000_FFFF_FFFF;
    b    = op[3] ? s : (imm[31] && w64 ? 64'hFFFF_FFFF_0000_0000 + imm : {32'd0, imm});
    b    = b & lowm;
    a    = d & lowm;
    sh   = w64 ? int'(b % 64) : int'(b % 32);
    v    = d;
    if (op[7:4] != 4'hB && off != 0) ill = 1'b1;
    case (op[7:4])
      4'h0: v = a + b;
      4'h1: v = a - b;
      4'h2: v = a * b;
      4'h4: v = a | b;
      4'h5: v = a & b;
      4'hA: v = a ^ b;
      4'h6: v = a << sh;
      4'h7: v = a >> sh;
      4'hC: v = (a >> sh) | ((w64 ? a[63] : a[31]) ? (lowm & ~(lowm >> sh)) : 64'd0);
      4'h8: v = 64'd0 - a;
      4'hB: begin
        n = int'(off);
        if (n == 0) v = b;
        else if (n == 8 || n == 16 || (n == 32 && w64)) begin
          v = b & ((64'd1 << n) - 1);
          if (v[n-1]) v = v - (64'd1 << n);
        end else ill = 1'b1;
      end
      4'hD: begin
        if (w64 && op[3]) ill = 1'b1;
        flip = w64 ? 1'b1 : (op[3] ? 1'b1 : 1'b0);
        if (imm == 16 || imm == 32 || imm == 64) begin
          n = int'(imm) / 8;
          v = 64'd0;
          for (int j = 0; j < n; j++)
            v[8*j +: 8] = flip ? d[8*(n-1-j) +: 8] : d[8*j +: 8];
        end else ill = 1'b1;
      end
      default: ill = 1'b1;
    endcase
    if (op[7:4] != 4'hD) v = v & lowm;
    if (ill) v = d;
    return {ill, v};
  endfunction

  task automatic apply(input logic [7:0] op, input logic [15:0] off, input logic [31:0] imm,
                       input logic [63:0] d, input logic [63:0] s);
    @(posedge clk);
    #1;
    op_code = op; op_offset = off; op_imm = imm; dst_val = d; src_val = s;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [64:0] exp);
    checks++;
    if ({illegal, result} !== exp) begin
      fails++;
      $display("FAIL %s op=%02h off=%0d imm=%08h: got ill=%0b res=%016h, expected ill=%0b res=%016h",
               tag, op_code, op_offset, op_imm, illegal, result, exp[64], exp[63:0]);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op, input logic ill);
    if (ill) return "R9";
    case (op[7:4])
      4'h6, 4'h7, 4'hC: return "R4";
      4'h8: return "R5";
      4'hB: return "R6";
      4'hD: return (op[2:0] == 3'd7) ? "R7" : "R8";
      default: return "R3";
    endcase
  endfunction

  logic [15:0] offs [5] = '{16'd0, 16'd8, 16'd16, 16'd32, 16'd3};
  logic [31:0] imms [5] = '{32'd16, 32'd32, 32'd64, 32'hFFFF_FFC5, 32'h0000_0021};
  logic [63:0] dvs  [3] = '{64'h8123_4567_89AB_CDEF, 64'h0000_0000_FFFF_FF80, 64'h7FFF_FFFF_0000_8001};
  logic [63:0] svs  [3] = '{64'h0000_0000_0000_0044, 64'hFFFF_FFFF_8000_8081, 64'h0000_0000_0000_003F};

  initial begin
    logic [64:0] e;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (illegal !== 1'b1 || result !== 64'd0) begin
      fails++;
      $display("FAIL R1 reset state: got ill=%0b res=%016h, expected ill=1 res=0", illegal, result);
    end
    apply(8'h0F, 16'd0, 32'd0, 64'h0000_0001_FFFF_FFFF, 64'd1);
    check("R1", {1'b0, 64'h0000_0002_0000_0000});
    apply(8'h0C, 16'd0, 32'd0, 64'h0000_0001_FFFF_FFFF, 64'd1);
    check("R1", {1'b0, 64'd0});
    apply(8'h07, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd100);
    check("R2", {1'b0, 64'd4});
    apply(8'h04, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd100);
    check("R2", {1'b0, 64'd4});
    apply(8'h0F, 16'd0, 32'hFFFF_FFFF, 64'd5, 64'd100);
    check("R2", {1'b0, 64'd105});
    for (int op = 0; op < 256; op++)
      for (int oi = 0; oi < 5; oi++)
        for (int ii = 0; ii < 5; ii++)
          for (int di = 0; di < 3; di++) begin
            apply(op[7:0], offs[oi], imms[ii], dvs[di], svs[di]);
            e = model(op[7:0], offs[oi], imms[ii], dvs[di], svs[di]);
            check(tag_of(op[7:0], e[64]), e);
          end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule